// File: doc/BRIEF.md
# Mode-Selected 16-Bit Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a 16-bit datapath. Two operand words and a single carry bit enter, and a three-bit mode code picks one of seven operations. The operations are copy, add with carry, subtract with borrow, three bitwise functions and an equality test. The output is one 16-bit word and one carry bit. There are no registers inside, so the outputs follow the inputs within the same cycle.

Subtraction is formed as the first operand plus the inverted second operand plus the inverted borrow. The carry output therefore reads as "no borrow". The adder core is either a plain ripple chain or a grouped lookahead chain, selected by a parameter. Both variants give the same results.

Top module: `alu16`

## Requirements
- R1: Mode 000 (copy) drives result equal to op_a and carry_out to 0.
- R2: Mode 001 (add) gives {carry_out, result} equal to op_a + op_b + carry_in as a 17-bit unsigned sum.
- R3: Mode 010 (subtract) gives result = (op_a - op_b - carry_in) mod 2^16. carry_out is 1 exactly when op_a >= op_b + carry_in, meaning no borrow occurred.
- R4: Mode 011 gives result = op_a AND op_b, bit by bit.
- R5: Mode 100 gives result = op_a OR op_b, bit by bit.
- R6: Mode 101 gives result = op_a XOR op_b, bit by bit.
- R7: Mode 110 (equality) gives result 16'h0001 when op_a equals op_b and 16'h0000 otherwise.
- R8: Mode 111 is reserved and drives result to 16'h0000.
- R9: In every mode other than add and subtract, carry_out is 0 and carry_in has no effect on either output.
- R10: The outputs are a combinational function of the present inputs, with no state. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry for add, borrow for subtract |
| mode | input | 3 | Operation select code |
| result | output | 16 | Operation result |
| carry_out | output | 1 | Add carry, or inverted borrow for subtract; 0 otherwise |

## Verification
The embedded assertions check several properties whenever the inputs settle. They check the 17-bit add and subtract identities and that carry_out stays low outside the arithmetic modes. They also check that the equality output takes only the values zero and one, and that the reserved code yields zero. The bench's scenarios cover the rest. Some corner operands push the carry chain end to end, such as all-ones plus one, and zero minus one with and without borrow. Toggling carry_in under the non-arithmetic modes shows it has no effect. Replaying earlier inputs after unrelated traffic shows the block holds no state.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
   typedef enum logic [2:0] {
      MD_COPY = 3'b000,
      MD_ADD  = 3'b001,
      MD_SUB  = 3'b010,
      MD_AND  = 3'b011,
      MD_OR   = 3'b100,
      MD_XOR  = 3'b101,
      MD_EQ   = 3'b110,
      MD_RSVD = 3'b111
   } alu_mode_e;

   typedef enum logic [1:0] {
      BW_AND = 2'd0,
      BW_OR  = 2'd1,
      BW_XOR = 2'd2
   } bw_op_e;

   localparam int MODE_W = 3;
endpackage

// File: rtl/alu16_adder.sv
module alu16_adder #(
   parameter int WIDTH         = 16,
   parameter int GROUP         = 4,
   parameter bit USE_LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int NGRP = WIDTH / GROUP;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu16_adder: WIDTH must be at least 2");
   end
   if (USE_LOOKAHEAD && (GROUP < 1 || (WIDTH % GROUP) != 0)) begin : g_bad_group
      $error("alu16_adder: GROUP must divide WIDTH");
   end

   logic [WIDTH-1:0] gen_b;
   logic [WIDTH-1:0] prop_b;
   assign gen_b  = x & y;
   assign prop_b = x ^ y;

   if (USE_LOOKAHEAD) begin : g_lookahead
      always_comb begin
         logic             grp_g;
         logic             grp_p;
         logic             cg;
         logic [WIDTH:0]   c;
         c  = '0;
         cg = cin;
         for (int gi = 0; gi < NGRP; gi++) begin
            grp_g = 1'b0;
            grp_p = 1'b1;
            c[gi*GROUP] = cg;
            for (int k = 0; k < GROUP; k++) begin
               grp_g = gen_b[gi*GROUP+k] | (prop_b[gi*GROUP+k] & grp_g);
               grp_p = grp_p & prop_b[gi*GROUP+k];
               c[gi*GROUP+k+1] = gen_b[gi*GROUP+k] | (prop_b[gi*GROUP+k] & c[gi*GROUP+k]);
            end
            cg = grp_g | (grp_p & cg);
         end
         sum  = prop_b ^ c[WIDTH-1:0];
         cout = cg;
      end
   end else begin : g_ripple
      always_comb begin
         logic [WIDTH:0] c;
         c[0] = cin;
         for (int i = 0; i < WIDTH; i++) begin
            c[i+1] = gen_b[i] | (prop_b[i] & c[i]);
         end
         sum  = prop_b ^ c[WIDTH-1:0];
         cout = c[WIDTH];
      end
   end
endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise
   import alu16_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  bw_op_e           op,
   output logic [WIDTH-1:0] z
);
   if (WIDTH < 1) begin : g_bad_width
      $error("alu16_bitwise: WIDTH must be positive");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         unique case (op)
            BW_AND:  z[i] = x[i] & y[i];
            BW_OR:   z[i] = x[i] | y[i];
            BW_XOR:  z[i] = x[i] ^ y[i];
            default: z[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/alu16_eq.sv
module alu16_eq #(
   parameter int WIDTH = 16,
   parameter int CHUNK = 4
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic             same
);
   localparam int NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
   localparam int PADW   = NCHUNK * CHUNK;

   if (CHUNK < 1) begin : g_bad_chunk
      $error("alu16_eq: CHUNK must be positive");
   end

   logic [PADW-1:0]   diff;
   logic [NCHUNK-1:0] chunk_hit;
   assign diff = PADW'(x ^ y);

   for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
      assign chunk_hit[k] = ~|diff[k*CHUNK +: CHUNK];
   end

   assign same = &chunk_hit;
endmodule

// File: rtl/alu16.sv
module alu16
   import alu16_pkg::*;
#(
   parameter int WIDTH         = 16,
   parameter int GROUP         = 4,
   parameter bit USE_LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   input  logic [2:0]       mode,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   if (WIDTH < 2) begin : g_bad_width
      $error("alu16: WIDTH must be at least 2");
   end

   alu_mode_e        md;
   logic             is_sub;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH-1:0] add_sum;
   logic             add_cout;
   bw_op_e           bw_sel;
   logic [WIDTH-1:0] bw_z;
   logic             eq_hit;

   assign md      = alu_mode_e'(mode);
   assign is_sub  = (md == MD_SUB);
   assign add_y   = is_sub ? ~op_b : op_b;
   assign add_cin = is_sub ? ~carry_in : carry_in;

   alu16_adder #(
      .WIDTH(WIDTH), .GROUP(GROUP), .USE_LOOKAHEAD(USE_LOOKAHEAD)
   ) i_adder (
      .x(op_a), .y(add_y), .cin(add_cin), .sum(add_sum), .cout(add_cout)
   );

   always_comb begin
      unique case (md)
         MD_OR:   bw_sel = BW_OR;
         MD_XOR:  bw_sel = BW_XOR;
         default: bw_sel = BW_AND;
      endcase
   end

   alu16_bitwise #(.WIDTH(WIDTH)) i_bitwise (
      .x(op_a), .y(op_b), .op(bw_sel), .z(bw_z)
   );

   alu16_eq #(.WIDTH(WIDTH), .CHUNK(GROUP)) i_eq (
      .x(op_a), .y(op_b), .same(eq_hit)
   );

   always_comb begin
      result    = '0;
      carry_out = 1'b0;
      unique case (md)
         MD_COPY: result = op_a;
         MD_ADD, MD_SUB: begin
            result    = add_sum;
            carry_out = add_cout;
         end
         MD_AND, MD_OR, MD_XOR: result = bw_z;
         MD_EQ:   result = {{(WIDTH-1){1'b0}}, eq_hit};
         default: result = '0;
      endcase
   end

   // Immediate checks on settled outputs, next to the output mux.
   logic [WIDTH:0] chk_add;
   logic [WIDTH:0] chk_sub;
   assign chk_add = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
   assign chk_sub = {1'b0, op_a} - {1'b0, op_b} - {{WIDTH{1'b0}}, carry_in};

   always_comb begin
      if (md == MD_ADD)
         a_r2_add_sum: assert ({carry_out, result} == chk_add)
            else $error("R2 add identity broken");
      if (md == MD_SUB)
         a_r3_sub_borrow: assert (result == chk_sub[WIDTH-1:0] && carry_out == ~chk_sub[WIDTH])
            else $error("R3 subtract identity broken");
      if (md != MD_ADD && md != MD_SUB)
         a_r9_cout_low: assert (carry_out == 1'b0)
            else $error("R9 carry_out high outside arithmetic");
      if (md == MD_EQ)
         a_r7_eq_binary: assert (result[WIDTH-1:1] == '0 && result[0] == (op_a == op_b))
            else $error("R7 equality output malformed");
      if (md == MD_RSVD)
         a_r8_reserved_zero: assert (result == '0)
            else $error("R8 reserved mode nonzero");
      if (md == MD_COPY)
         a_r1_copy: assert (result == op_a)
            else $error("R1 copy mismatch");
   end
endmodule

// File: tb/test_alu16.sv
module test_alu16;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         carry_in = 1'b0;
   logic [2:0]   mode = 3'b000;
   logic [W-1:0] result;
   logic         carry_out;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] lfsr = 32'hACE1_1234;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu16 i_alu16 (
      .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .mode(mode),
      .result(result), .carry_out(carry_out)
   );

   function automatic logic [16:0] model(input logic [2:0] m, input logic [15:0] a,
                                         input logic [15:0] b, input logic c);
      int s;
      case (m)
         3'b000: return {1'b0, a};
         3'b001: begin
            s = int'(a) + int'(b) + int'(c);
            return {s > 65535, s[15:0]};
         end
         3'b010: begin
            s = int'(a) - int'(b) - int'(c);
            return {s >= 0, s[15:0]};
         end
         3'b011: return {1'b0, a & b};
         3'b100: return {1'b0, a | b};
         3'b101: return {1'b0, a ^ b};
         3'b110: return (a == b) ? 17'h00001 : 17'h00000;
         default: return 17'h00000;
      endcase
   endfunction

   function automatic logic [15:0] next_rand();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr[15:0] ^ lfsr[31:16];
   endfunction

   task automatic apply(input logic [2:0] m, input logic [15:0] a,
                        input logic [15:0] b, input logic c);
      @(negedge clk);
      mode = m; op_a = a; op_b = b; carry_in = c;
      #1;
   endtask

   task automatic check(input string req, input logic [16:0] exp);
      n_checks++;
      if ({carry_out, result} !== exp) begin
         n_fail++;
         $display("FAIL %s mode=%b a=%h b=%h cin=%b actual={%b,%h} expected={%b,%h}",
                  req, mode, op_a, op_b, carry_in, carry_out, result, exp[16], exp[15:0]);
      end
   endtask

   task automatic run(input string req, input logic [2:0] m, input logic [15:0] a,
                      input logic [15:0] b, input logic c);
      apply(m, a, b, c);
      check(req, model(m, a, b, c));
   endtask

   task automatic t_initial_state();
      #1;
      check("R1 initial", 17'h00000);
   endtask

   task automatic t_copy();
      run("R1", 3'b000, 16'hBEEF, 16'h1234, 1'b1);
      run("R1", 3'b000, 16'h0000, 16'hFFFF, 1'b0);
   endtask

   task automatic t_add();
      run("R2", 3'b001, 16'hFFFF, 16'h0001, 1'b0);
      run("R2", 3'b001, 16'hFFFF, 16'h0000, 1'b1);
      run("R2", 3'b001, 16'hFFFF, 16'hFFFF, 1'b1);
      run("R2", 3'b001, 16'h7FFF, 16'h0001, 1'b0);
      apply(3'b001, 16'h1234, 16'h4321, 1'b1);
      check("R2 literal", 17'h05556);
   endtask

   task automatic t_sub();
      run("R3", 3'b010, 16'h0000, 16'h0001, 1'b0);
      run("R3", 3'b010, 16'h0005, 16'h0005, 1'b0);
      run("R3", 3'b010, 16'h0005, 16'h0005, 1'b1);
      run("R3", 3'b010, 16'h0000, 16'h0000, 1'b1);
      apply(3'b010, 16'h1000, 16'h0001, 1'b1);
      check("R3 literal", 17'h10FFE);
   endtask

   task automatic t_bitwise();
      run("R4", 3'b011, 16'hF0F0, 16'hFF00, 1'b0);
      run("R5", 3'b100, 16'hF0F0, 16'h0F0F, 1'b0);
      run("R6", 3'b101, 16'hAAAA, 16'hFFFF, 1'b0);
      apply(3'b101, 16'h00FF, 16'h0FF0, 1'b0);
      check("R6 literal", 17'h00F0F);
   endtask

   task automatic t_equal();
      run("R7", 3'b110, 16'h5A5A, 16'h5A5A, 1'b0);
      run("R7", 3'b110, 16'h5A5A, 16'h5A5B, 1'b0);
      run("R7", 3'b110, 16'h8000, 16'h0000, 1'b1);
      apply(3'b110, 16'hFFFF, 16'hFFFF, 1'b1);
      check("R7 literal", 17'h00001);
   endtask

   task automatic t_reserved();
      run("R8", 3'b111, 16'hFFFF, 16'hFFFF, 1'b1);
      apply(3'b111, 16'h1234, 16'h0000, 1'b0);
      check("R8 literal", 17'h00000);
   endtask

   task automatic t_cin_no_effect();
      for (int m = 0; m < 8; m++) begin
         if (m == 1 || m == 2) continue;
         apply(3'(m), 16'hFFFF, 16'hFFFF, 1'b0);
         check("R9 cin=0", model(3'(m), 16'hFFFF, 16'hFFFF, 1'b0));
         apply(3'(m), 16'hFFFF, 16'hFFFF, 1'b1);
         check("R9 cin=1", model(3'(m), 16'hFFFF, 16'hFFFF, 1'b0));
      end
   endtask

   task automatic t_stateless();
      run("R10 first", 3'b001, 16'h8001, 16'h7FFF, 1'b0);
      run("R10 other", 3'b101, 16'h1111, 16'h2222, 1'b1);
      run("R10 other", 3'b010, 16'h0000, 16'hFFFF, 1'b1);
      run("R10 replay", 3'b001, 16'h8001, 16'h7FFF, 1'b0);
   endtask

   task automatic t_sweep();
      for (int n = 0; n < 200; n++) begin
         logic [15:0] a;
         logic [15:0] b;
         a = next_rand();
         b = (n % 5 == 0) ? a : next_rand();
         for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 2; c++) begin
               run("R2 R3 R4 R5 R6 R7 sweep", 3'(m), a, b, c[0]);
            end
         end
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      t_initial_state();
      t_copy();
      t_add();
      t_sub();
      t_bitwise();
      t_equal();
      t_reserved();
      t_cin_no_effect();
      t_stateless();
      t_sweep();
      finish_run();
   end
endmodule